// File: doc/BRIEF.md
# Serial Register Interface Controller

This block is a clocked serial slave that lets a host reach the configuration and result registers of a measurement converter over a three-wire link: a serial clock, a data input and a data output. Every access opens with a command byte that names a target register and says whether the following phase is a read or a write. The data phase that follows is 8 clocks long for the configuration registers. For the conversion result it is 16 or 24 clocks, depending on a length bit held in the filter high register.

The converter core delivers each new result through a load strobe. A ready flag, active low, goes low when a result is captured. It goes high again only once the host has clocked out every bit of that result. If the host loses track of the frame, it can drive a long run of ones; the block then drops whatever it was doing and waits for a fresh command byte. The serial inputs are brought into the system clock domain through synchronisers, and both serial clock edges are found there. Input bits are taken on the rising serial clock edge, output bits are launched on the falling edge, and every field goes most significant bit first.

Top module: `sri_ctrl`

## Requirements
- R1: After a synchronous reset, the filter high register reads 0x01, the filter low register reads 0x40, the test register reads 0x00, drdy_n is 1 and sdo is 0.
- R2: The first 8 serial bits after reset or after a completed access form a command byte. Bits 6:4 select the register and bit 3 set to 1 means read; bits 7 and 2:0 are ignored. The very next data phase then belongs to that register.
- R3: Registers 2 (filter high), 3 (filter low) and 4 (test) take an 8-bit write and return an 8-bit read, MSB first. sdo changes only after a falling serial clock edge.
- R4: Bit 4 of the filter high register always holds 0, whatever value is written to it.
- R5: A one-cycle conv_load pulse captures conv_data into the result register (code 5) and drives drdy_n to 0.
- R6: A read of code 5 is 16 clocks long and returns result bits 23:8 when filter high bit 6 is 0. It is 24 clocks long and returns all 24 bits when that bit is 1.
- R7: drdy_n stays 0 through a result read until the last clock of that read, and is 1 after it.
- R8: 32 consecutive rising-edge samples of sdi at 1 return the block to waiting for a command byte, from any frame position.
- R9: Writing 0x00 to the test register clears it, and a hardware reset restores it to 0x00 from any value.
- R10: Codes 0, 1, 6 and 7 carry an 8-bit data phase. A read of them returns zeros, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| conv_load | input | 1 | One-cycle strobe that a new result is present |
| conv_data | input | 24 | Result word from the converter core |
| drdy_n | output | 1 | Result ready, active low |
| filt_hi | output | 8 | Filter high register contents |
| filt_lo | output | 8 | Filter low register contents |
| test_reg | output | 8 | Test register contents |

## Verification
The bench checks the ready flag one clock before the end of a 16-bit result read as well as after it. A design that released the flag early, or that counted a fixed length, fails that check. It reads results at both word lengths. A controller that ignored the length bit would send the wrong number of bits or hang in the data phase. The bench also pushes the frame out of alignment with three stray bits and then sends 32 ones. A design that missed the run, or restarted its count at the wrong point, would decode the following command byte wrongly. Writes of all ones to the filter high register and writes to unmapped codes show a leaking zero bit or a stray register update.

// File: rtl/sri_pkg.sv
// Package: shared codes and types for the serial register interface.
// Assumes a 3-bit register select field in the command byte.
package sri_pkg;
    typedef enum logic {ST_CMD, ST_DATA} frame_st_t;

    localparam logic [2:0] SEL_FHI  = 3'd2;
    localparam logic [2:0] SEL_FLO  = 3'd3;
    localparam logic [2:0] SEL_TEST = 3'd4;
    localparam logic [2:0] SEL_RES  = 3'd5;

    localparam logic [7:0] FHI_RST  = 8'h01;
    localparam logic [7:0] FLO_RST  = 8'h40;
    localparam logic [7:0] TEST_RST = 8'h00;

    localparam int FHI_LEN_BIT  = 6;
    localparam int FHI_ZERO_BIT = 4;
    localparam int CMD_RD_BIT   = 3;
    localparam int CMD_SEL_LSB  = 4;
endpackage

// File: rtl/sri_sync_edge.sv
// Synchroniser and edge finder: brings sclk and sdi into the clk domain
// and gives one-cycle pulses on rising and falling serial clock edges.
// Assumes sclk half periods of at least STAGES+1 clk cycles.
module sri_sync_edge #(
    parameter int   STAGES    = 2,
    parameter logic SCLK_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_q;
    logic [TOP:0] sdi_q;
    logic         sclk_prev;

    // Shift both serial inputs through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= {STAGES{SCLK_IDLE}};
            sdi_q     <= '0;
            sclk_prev <= SCLK_IDLE;
        end else begin
            sclk_q    <= {sclk_q[TOP-1:0], sclk_i};
            sdi_q     <= {sdi_q[TOP-1:0], sdi_i};
            sclk_prev <= sclk_q[TOP];
        end
    end

    assign rise_o = sclk_q[TOP] & ~sclk_prev;
    assign fall_o = ~sclk_q[TOP] & sclk_prev;
    assign sdi_o  = sdi_q[TOP];
endmodule

// File: rtl/sri_frame.sv
// Frame tracker: collects the command byte, counts the data phase,
// flags completed words and watches for the run of ones that resyncs.
// Assumes rise_i is a single-cycle pulse with sdi_i valid alongside it.
module sri_frame
    import sri_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SHORT_W     = 16,
    parameter int REG_W       = 8,
    parameter int RESYNC_ONES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             sdi_i,
    input  logic             long_word_i,
    output logic             cmd_done_o,
    output logic             word_done_o,
    output logic             resync_o,
    output logic [2:0]       sel_o,
    output logic             rd_o,
    output logic             in_read_o,
    output logic             res_open_o,
    output logic [REG_W-1:0] wdata_o
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam int OW = $clog2(RESYNC_ONES);

    frame_st_t        state;
    logic [CW-1:0]    bit_cnt;
    logic [CW-1:0]    len_q;
    logic [2:0]       sel_q;
    logic             rd_q;
    logic [REG_W-1:0] rx;
    logic [OW-1:0]    ones_cnt;

    logic [REG_W-1:0] rx_next;
    logic [2:0]       new_sel;
    logic             new_rd;
    logic             hit;

    // Next shift contents and decoded fields of a byte in progress.
    always_comb begin
        rx_next = {rx[REG_W-2:0], sdi_i};
        new_sel = rx_next[CMD_SEL_LSB +: 3];
        new_rd  = rx_next[CMD_RD_BIT];
    end

    assign hit         = rise_i & sdi_i & (ones_cnt == OW'(RESYNC_ONES - 1));
    assign cmd_done_o  = rise_i & ~hit & (state == ST_CMD) &
                         (bit_cnt == CW'(REG_W - 1));
    assign word_done_o = rise_i & ~hit & (state == ST_DATA) &
                         (bit_cnt == len_q - CW'(1));
    assign resync_o    = hit;
    assign sel_o       = (state == ST_CMD) ? new_sel : sel_q;
    assign rd_o        = (state == ST_CMD) ? new_rd  : rd_q;
    assign in_read_o   = (state == ST_DATA) & rd_q;
    assign res_open_o  = in_read_o & (sel_q == SEL_RES);
    assign wdata_o     = rx_next;

    // Count consecutive ones seen on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_cnt <= '0;
        else if (rise_i)
            ones_cnt <= (sdi_i && !hit) ? ones_cnt + OW'(1) : '0;
    end

    // Shift in every sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx <= '0;
        else if (rise_i)
            rx <= rx_next;
    end

    // Step the frame state, bit counter and latched command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
            len_q   <= CW'(REG_W);
            sel_q   <= '0;
            rd_q    <= 1'b0;
        end else if (hit) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
        end else if (cmd_done_o) begin
            state   <= ST_DATA;
            bit_cnt <= '0;
            sel_q   <= new_sel;
            rd_q    <= new_rd;
            if (new_sel == SEL_RES)
                len_q <= long_word_i ? CW'(DATA_W) : CW'(SHORT_W);
            else
                len_q <= CW'(REG_W);
        end else if (word_done_o) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
        end else if (rise_i) begin
            bit_cnt <= bit_cnt + CW'(1);
        end
    end

    // R8
    resync_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state == ST_CMD) && (bit_cnt == '0));

    // R2
    cmd_opens_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |=> (state == ST_DATA) && (sel_q == $past(new_sel)));
endmodule

// File: rtl/sri_regfile.sv
// Register file: the filter and test registers, the result register with
// its ready flag, and the left-aligned read value for the selected code.
// Assumes wr_i and rd_done_i are single-cycle strobes from the frame tracker.
module sri_regfile
    import sri_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [2:0]        sel_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              conv_load_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic              res_busy_i,
    input  logic              rd_done_i,
    output logic [REG_W-1:0]  fhi_o,
    output logic [REG_W-1:0]  flo_o,
    output logic [REG_W-1:0]  test_o,
    output logic              drdy_n_o,
    output logic [DATA_W-1:0] rd_word_o
);
    localparam int PAD_W = DATA_W - REG_W;
    localparam logic [REG_W-1:0] ZERO_MASK = ~(REG_W'(1) << FHI_ZERO_BIT);

    logic [DATA_W-1:0] res_q;

    // Update the configuration registers on a completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fhi_o  <= FHI_RST;
            flo_o  <= FLO_RST;
            test_o <= TEST_RST;
        end else if (wr_i) begin
            case (sel_i)
                SEL_FHI:  fhi_o  <= wdata_i & ZERO_MASK;
                SEL_FLO:  flo_o  <= wdata_i;
                SEL_TEST: test_o <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Capture results and drive the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q    <= '0;
            drdy_n_o <= 1'b1;
        end else if (rd_done_i) begin
            drdy_n_o <= 1'b1;
        end else if (conv_load_i && !res_busy_i) begin
            res_q    <= conv_data_i;
            drdy_n_o <= 1'b0;
        end
    end

    // Left-aligned read value for the addressed register.
    always_comb begin
        case (sel_i)
            SEL_FHI:  rd_word_o = {fhi_o,  {PAD_W{1'b0}}};
            SEL_FLO:  rd_word_o = {flo_o,  {PAD_W{1'b0}}};
            SEL_TEST: rd_word_o = {test_o, {PAD_W{1'b0}}};
            SEL_RES:  rd_word_o = res_q;
            default:  rd_word_o = '0;
        endcase
    end

    // R7
    drdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_n_o) |-> $past(rd_done_i));

    // R5
    drdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n_o) |-> $past(conv_load_i));

    // R4
    zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_FHI) |=> !fhi_o[FHI_ZERO_BIT]);
endmodule

// File: rtl/sri_tx.sv
// Transmit shifter: loads the read value when a read command completes,
// steps it on each rising serial edge and launches bits on falling edges.
// Assumes the load value is left-aligned to the MSB.
module sri_tx #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              active_i,
    output logic              sdo_o
);
    logic [DATA_W-1:0] tx;

    // Load or shift the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx <= '0;
        else if (load_i)
            tx <= load_val_i;
        else if (rise_i && active_i)
            tx <= {tx[DATA_W-2:0], 1'b0};
    end

    // Launch the current MSB after each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdo_o <= 1'b0;
        else if (fall_i)
            sdo_o <= active_i ? tx[DATA_W-1] : 1'b0;
    end

    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sdo_o));
endmodule

// File: rtl/sri_ctrl.sv
// Top level: serial slave giving a host access to the filter, test and
// result registers. Assumes sclk idles high and is much slower than clk.
module sri_ctrl
    import sri_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SHORT_W     = 16,
    parameter int REG_W       = 8,
    parameter int RESYNC_ONES = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic              conv_load,
    input  logic [DATA_W-1:0] conv_data,
    output logic              drdy_n,
    output logic [REG_W-1:0]  filt_hi,
    output logic [REG_W-1:0]  filt_lo,
    output logic [REG_W-1:0]  test_reg
);
    logic             rise, fall, sdi_s;
    logic             cmd_done, word_done, resync;
    logic [2:0]       sel;
    logic             rd, in_read, res_open;
    logic [REG_W-1:0] wdata;
    logic [DATA_W-1:0] rd_word;
    logic             wr_stb, rd_done, res_busy, tx_load;

    assign wr_stb   = word_done & ~rd;
    assign rd_done  = word_done & rd & (sel == SEL_RES);
    assign res_busy = res_open | (cmd_done & rd & (sel == SEL_RES));
    assign tx_load  = cmd_done & rd;

    sri_sync_edge #(.STAGES(SYNC_STAGES), .SCLK_IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
        .rise_o(rise), .fall_o(fall), .sdi_o(sdi_s)
    );

    sri_frame #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .REG_W(REG_W),
                .RESYNC_ONES(RESYNC_ONES)) u_frame (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .sdi_i(sdi_s),
        .long_word_i(filt_hi[FHI_LEN_BIT]),
        .cmd_done_o(cmd_done), .word_done_o(word_done), .resync_o(resync),
        .sel_o(sel), .rd_o(rd), .in_read_o(in_read),
        .res_open_o(res_open), .wdata_o(wdata)
    );

    sri_regfile #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_stb), .sel_i(sel),
        .wdata_i(wdata), .conv_load_i(conv_load), .conv_data_i(conv_data),
        .res_busy_i(res_busy), .rd_done_i(rd_done),
        .fhi_o(filt_hi), .flo_o(filt_lo), .test_o(test_reg),
        .drdy_n_o(drdy_n), .rd_word_o(rd_word)
    );

    sri_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .load_i(tx_load), .load_val_i(rd_word), .active_i(in_read),
        .sdo_o(sdo)
    );

    // R8
    resync_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> !word_done && !cmd_done);
endmodule

// File: tb/tb_sri_ctrl.sv
module tb_sri_ctrl;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        conv_load = 1'b0;
    logic [23:0] conv_data = '0;
    logic        drdy_n;
    logic [7:0]  filt_hi, filt_lo, test_reg;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sri_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
        .conv_load(conv_load), .conv_data(conv_data), .drdy_n(drdy_n),
        .filt_hi(filt_hi), .filt_lo(filt_lo), .test_reg(test_reg)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = b;
        repeat (HALF) @(negedge clk);
        o    = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input int n, input logic [23:0] din, output logic [23:0] dout);
        logic b;
        dout = '0;
        for (int i = 0; i < n; i++) begin
            bit_io(din[n-1-i], b);
            dout = {dout[22:0], b};
        end
    endtask

    task automatic wr8(input logic [7:0] cmd, input logic [7:0] val);
        logic [23:0] d;
        xfer(8, {16'h0, cmd}, d);
        xfer(8, {16'h0, val}, d);
    endtask

    task automatic rd8(input logic [7:0] cmd, output logic [7:0] val);
        logic [23:0] d;
        xfer(8, {16'h0, cmd}, d);
        xfer(8, 24'h0, d);
        val = d[7:0];
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_result(input logic [23:0] v);
        @(negedge clk);
        conv_load = 1'b1;
        conv_data = v;
        @(negedge clk);
        conv_load = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 filt_hi", {16'h0, filt_hi}, 24'h01);
        chk("R1 filt_lo", {16'h0, filt_lo}, 24'h40);
        chk("R1 test_reg", {16'h0, test_reg}, 24'h00);
        chk("R1 drdy_n", {23'h0, drdy_n}, 24'h1);
        chk("R1 sdo", {23'h0, sdo}, 24'h0);
    endtask

    task automatic t_rw_lo();
        logic [7:0] v;
        wr8(8'h30, 8'hA5);
        chk("R2 filt_lo write", {16'h0, filt_lo}, 24'hA5);
        rd8(8'h38, v);
        chk("R3 filt_lo read", {16'h0, v}, 24'hA5);
        wr8(8'hB7, 8'h3C);   // bits 7 and 2:0 ignored: still write code 3
        chk("R2 ignored cmd bits", {16'h0, filt_lo}, 24'h3C);
    endtask

    task automatic t_zero_bit();
        logic [7:0] v;
        wr8(8'h20, 8'hFF);
        chk("R4 zero bit port", {16'h0, filt_hi}, 24'hEF);
        rd8(8'h28, v);
        chk("R4 zero bit read", {16'h0, v}, 24'hEF);
    endtask

    task automatic t_res16();
        logic [23:0] d;
        logic b;
        wr8(8'h20, 8'h01);
        load_result(24'hABCDEF);
        chk("R5 drdy low after load", {23'h0, drdy_n}, 24'h0);
        xfer(8, 24'h58, d);
        xfer(15, 24'h0, d);
        chk("R7 drdy low before last clock", {23'h0, drdy_n}, 24'h0);
        bit_io(1'b0, b);
        d = {d[22:0], b};
        chk("R6 16-bit result", {8'h0, d[15:0]}, 24'h00ABCD);
        chk("R7 drdy high after read", {23'h0, drdy_n}, 24'h1);
    endtask

    task automatic t_res24();
        logic [23:0] d;
        wr8(8'h20, 8'h41);
        load_result(24'h123456);
        chk("R5 drdy low 24", {23'h0, drdy_n}, 24'h0);
        xfer(8, 24'h58, d);
        xfer(24, 24'h0, d);
        chk("R6 24-bit result", d, 24'h123456);
        chk("R7 drdy high 24", {23'h0, drdy_n}, 24'h1);
        wr8(8'h20, 8'h01);
    endtask

    task automatic t_resync();
        logic [23:0] d;
        xfer(3, 24'h2, d);          // stray bits 0,1,0
        xfer(16, 24'hFFFF, d);
        xfer(16, 24'hFFFF, d);      // 32 ones in total
        wr8(8'h30, 8'h6B);
        chk("R8 aligned after ones", {16'h0, filt_lo}, 24'h6B);
        chk("R8 filt_hi untouched", {16'h0, filt_hi}, 24'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr8(8'h00, 8'h77);
        wr8(8'h70, 8'h55);
        chk("R10 filt_hi kept", {16'h0, filt_hi}, 24'h01);
        chk("R10 filt_lo kept", {16'h0, filt_lo}, 24'h6B);
        chk("R10 test kept", {16'h0, test_reg}, 24'h00);
        rd8(8'h78, v);
        chk("R10 read zero", {16'h0, v}, 24'h00);
    endtask

    task automatic t_test_reg();
        logic [7:0] v;
        wr8(8'h40, 8'h5A);
        chk("R9 test written", {16'h0, test_reg}, 24'h5A);
        rd8(8'h48, v);
        chk("R3 test read", {16'h0, v}, 24'h5A);
        wr8(8'h40, 8'h00);
        chk("R9 test cleared", {16'h0, test_reg}, 24'h00);
        wr8(8'h40, 8'hC3);
        hw_reset();
        chk("R9 test after hw reset", {16'h0, test_reg}, 24'h00);
        chk("R1 filt_lo after hw reset", {16'h0, filt_lo}, 24'h40);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not finish");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        join_none
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_rw_lo();
        t_zero_bit();
        t_res16();
        t_res24();
        t_resync();
        t_unmapped();
        t_test_reg();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule